// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block serves one bus-master disk DMA channel. Host memory holds a table of 8-byte descriptors, each naming one memory region. The walker fetches these descriptors one at a time over a plain request/response read port. It keeps track of the region currently being drained. The drive side asks for a byte total, and the walker answers with a stream of `{address, length}` segments that add up to that total.

A region that is larger than one request is split. What is left of it carries over to the next request, so the following request resumes mid-region.

A walk stops when the drive side's total has been met, which pulses `done`. It also stops when the table runs out first, which pulses `exhausted`. The table runs out when the entry flagged as final has been drained, or when the read pointer has moved a full 4096-byte page past the table base, whichever comes first. A `start` pulse rewinds the walker to the table base.

Top module: `prd_walker`

## Requirements
- R1: Each descriptor fetch reads 8 bytes at the table pointer. `mem_rsp_data[31:0]` is the region address and `mem_rsp_data[63:32]` is the control word. After each fetch the pointer advances by 8.
- R2: A region's byte count is control bits [15:0] with bit 0 treated as zero. Control bits [30:16] have no effect.
- R3: A masked count of zero gives a region of 65536 bytes.
- R4: Control bit 31 marks the final descriptor. Once that region is drained, a request with bytes still owed ends with an `exhausted` pulse and no further fetch.
- R5: When the region is empty and the pointer is 4096 or more bytes past the base latched at `start`, the walk ends with `exhausted` and does not fetch.
- R6: Each segment length is min(bytes still owed, bytes left in the region). The region address advances and its count drops by that length. A partly used region carries into the next request.
- R7: `done` pulses for one cycle once a request is fully served. A request of zero bytes gives `done` with no segment and no fetch.
- R8: `start`, taken only while idle, latches `base_addr` as table base and pointer and clears the region address, count and final flag.
- R9: At most one fetch is outstanding. `mem_req` stays high with a stable `mem_addr` until `mem_rsp_valid`, and falls in the following cycle.
- R10: After reset, `busy`, `mem_req`, `seg_valid`, `done` and `exhausted` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | rewind to table base (idle only) |
| base_addr | input | AW | table base address |
| req_valid | input | 1 | new byte request (idle only) |
| req_len | input | LW | bytes requested |
| busy | output | 1 | a request is being served |
| mem_req | output | 1 | descriptor read pending |
| mem_addr | output | AW | descriptor read address |
| mem_rsp_valid | input | 1 | read data returned |
| mem_rsp_data | input | 64 | descriptor: [31:0] address, [63:32] control |
| seg_valid | output | 1 | segment strobe |
| seg_addr | output | AW | segment start address |
| seg_len | output | 17 | segment byte length |
| done | output | 1 | request satisfied pulse |
| exhausted | output | 1 | table ended first pulse |

## Verification
A four-entry table is walked with a sweep of request sizes after each rewind. The sweep includes zero, odd sizes, sizes landing exactly on region ends, and sizes past the table total, which separates the `done` outcome from the `exhausted` outcome and checks the min rule at every boundary. A long run of equal small requests without a rewind checks that regions carry over between requests. A request made after the table has ended must return `exhausted` without any new fetch. A 512-entry table with no final flag checks that the page fail-safe alone stops the walk, and a mid-walk rewind checks that the region state is cleared.

// File: rtl/prd_walker.sv
module prd_walker #(
  parameter int AW         = 32,
  parameter int LW         = 20,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic          req_valid,
  input  logic [LW-1:0] req_len,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data,
  output logic          seg_valid,
  output logic [AW-1:0] seg_addr,
  output logic [16:0]   seg_len,
  output logic          done,
  output logic          exhausted
);
  localparam int CW = 17;
  localparam int MW = (LW > CW) ? LW : CW;

  typedef enum logic [1:0] {IDLE, WALK, FETCH} st_t;
  st_t st;

  logic [AW-1:0] tbase, ptr, raddr;
  logic [CW-1:0] rcnt;
  logic          rlast;
  logic [LW-1:0] need;

  wire [MW-1:0] need_w = MW'(need);
  wire [MW-1:0] cnt_w  = MW'(rcnt);
  wire [MW-1:0] take   = (need_w < cnt_w) ? need_w : cnt_w;

  wire [15:0]   masked  = mem_rsp_data[47:32] & 16'hfffe;
  wire [CW-1:0] new_cnt = (masked == 16'h0) ? {1'b1, 16'h0} : {1'b0, masked};
  wire          page_out = (ptr - tbase) >= AW'(PAGE_BYTES);

  assign busy     = (st != IDLE);
  assign mem_req  = (st == FETCH);
  assign mem_addr = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      tbase <= '0; ptr <= '0; raddr <= '0; rcnt <= '0; rlast <= 1'b0; need <= '0;
      seg_valid <= 1'b0; seg_addr <= '0; seg_len <= '0;
      done <= 1'b0; exhausted <= 1'b0;
    end else begin
      seg_valid <= 1'b0;
      done      <= 1'b0;
      exhausted <= 1'b0;
      case (st)
        IDLE: begin
          if (start) begin
            tbase <= base_addr;
            ptr   <= base_addr;
            raddr <= '0;
            rcnt  <= '0;
            rlast <= 1'b0;
          end else if (req_valid) begin
            need <= req_len;
            st   <= WALK;
          end
        end
        WALK: begin
          if (need == '0) begin
            done <= 1'b1;
            st   <= IDLE;
          end else if (rcnt != '0) begin
            seg_valid <= 1'b1;
            seg_addr  <= raddr;
            seg_len   <= CW'(take);
            raddr     <= raddr + AW'(take);
            rcnt      <= rcnt - CW'(take);
            need      <= need - LW'(take);
          end else if (rlast || page_out) begin
            exhausted <= 1'b1;
            st        <= IDLE;
          end else begin
            st <= FETCH;
          end
        end
        FETCH: begin
          if (mem_rsp_valid) begin
            raddr <= mem_rsp_data[AW-1:0];
            rcnt  <= new_cnt;
            rlast <= mem_rsp_data[63];
            ptr   <= ptr + AW'(8);
            st    <= WALK;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr));
  assert_one_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rsp_valid |=> !mem_req);
  assert_seg_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != 17'h0) && (seg_len <= 17'h10000));
  assert_fail_safe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr - tbase) < AW'(PAGE_BYTES));
  assert_single_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exhausted));
  assert_seg_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> busy);
endmodule

// File: tb/prd_walker_test.sv
module prd_walker_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, req_valid = 1'b0;
  logic [31:0] base_addr = '0;
  logic [19:0] req_len = '0;
  logic busy, mem_req, mem_rsp_valid, seg_valid, done, exhausted;
  logic [31:0] mem_addr, seg_addr;
  logic [63:0] mem_rsp_data;
  logic [16:0] seg_len;

  always #5 clk = ~clk;

  prd_walker uut (.clk, .rst_n, .start, .base_addr, .req_valid, .req_len, .busy,
    .mem_req, .mem_addr, .mem_rsp_valid, .mem_rsp_data, .seg_valid, .seg_addr,
    .seg_len, .done, .exhausted);

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] t_addr [0:1023];
  logic [31:0] t_ctl  [0:1023];
  logic [31:0] cur_base = '0;
  int fetches = 0;
  int act_n = 0;
  logic [31:0] act_a [0:1023];
  int          act_l [0:1023];
  logic [31:0] exp_a [0:1023];
  int          exp_l [0:1023];
  int exp_n, exp_fetch;
  bit exp_done;
  logic [31:0] m_ptr, m_addr, m_base;
  int m_cnt;
  bit m_last;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_rsp_valid) begin
        logic [31:0] off;
        off = mem_addr - cur_base;
        chk(off[2:0] == 3'b0 && off < 32'd8192, "R1", "fetch address", mem_addr, cur_base);
        mem_rsp_data  = {t_ctl[off[12:3]], t_addr[off[12:3]]};
        mem_rsp_valid = 1'b1;
        fetches++;
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (seg_valid && act_n < 1024) begin
        act_a[act_n] = seg_addr;
        act_l[act_n] = int'(seg_len);
        act_n++;
      end
    end
  end

  task automatic do_start(input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; base_addr = b;
    @(negedge clk);
    start = 1'b0;
    cur_base = b;
    m_base = b; m_ptr = b; m_addr = 0; m_cnt = 0; m_last = 0;
  endtask

  task automatic model(input int len);
    int need;
    need = len; exp_n = 0; exp_fetch = 0;
    forever begin
      if (need == 0) begin exp_done = 1; return; end
      if (m_cnt != 0) begin
        int s;
        s = (need < m_cnt) ? need : m_cnt;
        exp_a[exp_n] = m_addr; exp_l[exp_n] = s; exp_n++;
        m_addr += s; m_cnt -= s; need -= s;
      end else if (m_last || (m_ptr - m_base) >= 4096) begin
        exp_done = 0; return;
      end else begin
        logic [31:0] c;
        c = t_ctl[(m_ptr - m_base) >> 3];
        m_cnt = int'(c[15:0] & 16'hfffe);
        if (m_cnt == 0) m_cnt = 65536;
        m_addr = t_addr[(m_ptr - m_base) >> 3];
        m_last = c[31];
        m_ptr += 8;
        exp_fetch++;
      end
    end
  endtask

  task automatic run_req(input int len, input string tag);
    int t;
    model(len);
    @(negedge clk);
    act_n = 0; fetches = 0;
    req_valid = 1'b1; req_len = 20'(len);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!(done || exhausted) && t < 5000) begin @(negedge clk); t++; end
    chk(done == exp_done && exhausted == !exp_done, tag, "outcome done", done, exp_done);
    chk(act_n == exp_n, tag, "segment count", act_n, exp_n);
    chk(fetches == exp_fetch, tag, "fetch count", fetches, exp_fetch);
    for (int i = 0; i < exp_n && i < act_n; i++) begin
      chk(act_a[i] == exp_a[i], tag, "segment address", act_a[i], exp_a[i]);
      chk(act_l[i] == exp_l[i], tag, "segment length", act_l[i], exp_l[i]);
    end
  endtask

  task automatic load_small;
    for (int i = 0; i < 1024; i++) begin t_addr[i] = 32'hdead_0000 + i; t_ctl[i] = 32'h0000_0040; end
    t_addr[0] = 32'h2000_0000; t_ctl[0] = 32'h0000_0100;
    t_addr[1] = 32'h2001_0000; t_ctl[1] = 32'h1234_0201;
    t_addr[2] = 32'h2003_0000; t_ctl[2] = 32'h0000_0000;
    t_addr[3] = 32'h2005_0000; t_ctl[3] = 32'h8000_0011;
  endtask

  initial begin
    int sweep [13] = '{0, 1, 2, 3, 'h55, 'h100, 'h101, 'h2ff, 'h300,
                       'h10000, 'h10300, 'h10310, 'h20000};
    string tg;
    int k;
    load_small();
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !seg_valid && !done && !exhausted, "R10", "reset outputs",
        {busy, mem_req, seg_valid, done, exhausted}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !seg_valid && !done && !exhausted, "R10", "idle after reset",
        {busy, mem_req, seg_valid, done, exhausted}, 0);

    foreach (sweep[i]) begin
      tg = (sweep[i] == 0) ? "R7" : (sweep[i] <= 'h300) ? "R2" :
           (sweep[i] <= 'h10300) ? "R3" : "R4";
      do_start(32'h1000_0000);
      run_req(sweep[i], tg);
    end

    do_start(32'h1000_0000);
    k = 0;
    do begin
      run_req('h80, "R6");
      k++;
    end while (exp_done && k < 600);
    chk(k == 519, "R6", "requests until end", k, 519);
    run_req('h10, "R4");

    do_start(32'h1000_0000);
    run_req('h80, "R8");
    do_start(32'h1000_0000);
    run_req('h100, "R8");

    for (int i = 0; i < 1024; i++) begin t_addr[i] = 32'h4000_0000 + 32'(i * 16); t_ctl[i] = 32'h0000_0003; end
    t_ctl[700] = 32'h8000_0002;
    do_start(32'h3000_0000);
    run_req(4000, "R5");
    chk(fetches == 512, "R5", "fail-safe fetches", fetches, 512);
    run_req(2, "R5");

    do_start(32'h3000_0000);
    run_req(0, "R7");
    run_req(5, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule